// File: doc/BRIEF.md
# External Memory Bus Controller with Per-Select Timing

This block connects an internal single-transfer request port to a slow asynchronous external memory bus. A requester presents a chip-select index, a 9-bit word offset, a direction and 16-bit write data. The controller then runs one complete bus cycle on the pins: six active-low chip selects, a 9-bit address, a 16-bit data bus with its own output enable, and active-low read (OE) and write (WE) strobes. Read data comes back on a 16-bit result port. A one-cycle acknowledge closes the transfer.

Each chip select has its own timing set: the strobe length for reads and for writes, how long the select stays asserted after a write, the latency added before the first access to a page, and the number of idle turnaround cycles inserted after a read. A small configuration write port loads these values. A transfer copies the timing of its target select when it is accepted. A configuration write therefore never alters a bus cycle that is already running.

The requester raises `req_valid` with stable request fields and holds them until it sees `req_ack`. It drops `req_valid` in the acknowledge cycle. The chip-select index must be below six.

Top module: `extbus_ctrl`

## Requirements
- R1: Reset state: while reset is held and after it is released, with no request pending, all six chip selects, `bus_oe_n` and `bus_we_n` are high, `bus_dout_en` is low and `req_ack` is low. All timing fields reset to 0.
- R2: Strobe length: a read holds `bus_oe_n` low for RW+1 consecutive cycles and a write holds `bus_we_n` low for WW+1 cycles. RW and WW are the 4-bit read and write wait fields of the target select. OE and WE are never low together.
- R3: Write hold: after `bus_we_n` rises, the target chip select stays low for WH+1 further cycles, where WH is the 4-bit write hold field. Reads have no hold phase.
- R4: Write data drive: `bus_dout_en` is high from the first WE-low cycle until the chip select rises, which is WW+1+WH+1 cycles. `bus_dout` then carries the request's write data. `bus_dout_en` is low during reads, recovery and idle.
- R5: Recovery: before the select asserts, all chip selects are held high for max(1, RC) cycles, where RC is the 4-bit recovery field of the previous access's select. This happens when the previous access was a read and either the select changes or the new access is a write. No recovery follows a write, and none follows a read that is followed by a read on the same select.
- R6: First-page latency: an access is on a new page if there was no earlier access since reset, if its select differs from the previous access, if address bits [8:4] differ from the previous access, or if recovery was inserted. A new-page access keeps its select low for RD (read) or WD (write) extra cycles before the strobe. RD and WD are the 8-bit delta fields. Accesses that are not on a new page get no extra cycles.
- R7: Read data is sampled from `bus_din` on the last OE-low cycle and held on `rsp_rdata`. `req_ack` is high for exactly one cycle, the first cycle with all chip selects high after the select was low.
- R8: Configuration write: when `cfg_we` is high, `cfg_field` selects the field of select `cfg_cs` that is loaded from `cfg_data`. The field codes are 0 = read wait, 1 = write wait, 2 = write hold, 3 = recovery, 4 = read delta and 5 = write delta. The 4-bit fields take `cfg_data[3:0]`. Codes 6 and 7 change nothing. A write in the same cycle a request is accepted applies only from the next access.
- R9: During the select-low window, only the target chip select is low and `bus_addr` equals the request offset. At no time is more than one chip select low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request pending; held until acknowledge |
| req_write | input | 1 | 1 = write, 0 = read |
| req_cs | input | 3 | Target chip-select index, 0 to 5 |
| req_addr | input | 9 | Word offset driven on the bus |
| req_wdata | input | 16 | Write data |
| req_ack | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 16 | Last read result |
| cfg_we | input | 1 | Timing field write strobe |
| cfg_cs | input | 3 | Chip select whose field is written |
| cfg_field | input | 3 | Field code (see R8) |
| cfg_data | input | 8 | Field value |
| bus_cs_n | output | 6 | Active-low chip selects |
| bus_addr | output | 9 | External address |
| bus_dout | output | 16 | External write data |
| bus_dout_en | output | 1 | Data bus output enable |
| bus_din | input | 16 | External read data |
| bus_oe_n | output | 1 | Active-low read strobe |
| bus_we_n | output | 1 | Active-low write strobe |

## Verification
The hardest case to reach is the interaction of history-dependent behaviour. Whether recovery and first-page latency appear depends on the previous access's direction, select and page, and the recovery length comes from the previous select's registers, not the current one's. The stimulus table is therefore an ordered sequence built to create each history on purpose:
- a read then a read on the same page;
- a read then a write on the same select;
- a write then a read on a new select;
- a read then a read on a different select;
- page changes within one select.

The selects are programmed with different, extreme values (recovery 15, delta 255, recovery 0), so a count taken from the wrong source shows up as a wrong cycle count. The sampling point of read data is checked with a bus model that returns the number of OE-low cycles seen so far. The snapshot rule is checked by writing a timing field in the same cycle a request is accepted.

// File: rtl/extbus_pkg.sv
// Package: shared sizes, the per-select timing record and configuration
// field codes for the external bus controller.
package extbus_pkg;

    localparam int NUM_CS     = 6;
    localparam int CS_W       = 3;
    localparam int ADDR_W     = 9;
    localparam int DATA_W     = 16;
    localparam int PAGE_OFS_W = 4;
    localparam int WAIT_W     = 4;
    localparam int DELTA_W    = 8;
    localparam int CNT_W      = DELTA_W;

    // Timing set of one chip select
    typedef struct packed {
        logic [WAIT_W-1:0]  rd_wait;
        logic [WAIT_W-1:0]  wr_wait;
        logic [WAIT_W-1:0]  wr_hold;
        logic [WAIT_W-1:0]  recov;
        logic [DELTA_W-1:0] rd_delta;
        logic [DELTA_W-1:0] wr_delta;
    } timing_t;

    // Field select codes of the configuration port
    typedef enum logic [2:0] {
        FLD_RD_WAIT  = 3'd0,
        FLD_WR_WAIT  = 3'd1,
        FLD_WR_HOLD  = 3'd2,
        FLD_RECOV    = 3'd3,
        FLD_RD_DELTA = 3'd4,
        FLD_WR_DELTA = 3'd5
    } cfg_field_e;

    // Bus sequencer phases
    typedef enum logic [2:0] {
        PH_IDLE,
        PH_REC,
        PH_LAT,
        PH_STRB,
        PH_HOLD,
        PH_DONE
    } phase_e;

endpackage

// File: rtl/extbus_cfg_regs.sv
// Module: extbus_cfg_regs
// Holds one timing record per chip select and loads single fields from the
// configuration write port. Assumes field codes from extbus_pkg; unknown
// codes and out-of-range select indices change nothing.
module extbus_cfg_regs
    import extbus_pkg::*;
#(
    parameter int N_CS  = NUM_CS,
    parameter int IDX_W = CS_W
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     cfg_we,
    input  logic [IDX_W-1:0]         cfg_cs,
    input  logic [2:0]               cfg_field,
    input  logic [DELTA_W-1:0]       cfg_data,
    output timing_t [N_CS-1:0]       timing_q
);

    for (genvar g = 0; g < N_CS; g++) begin : g_slot
        timing_t slot_q;
        logic    hit;

        assign hit         = cfg_we && (cfg_cs == IDX_W'(g));
        assign timing_q[g] = slot_q;

        // Load the addressed field of this select's timing record
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                slot_q <= '0;
            end else if (hit) begin
                case (cfg_field)
                    FLD_RD_WAIT:  slot_q.rd_wait  <= cfg_data[WAIT_W-1:0];
                    FLD_WR_WAIT:  slot_q.wr_wait  <= cfg_data[WAIT_W-1:0];
                    FLD_WR_HOLD:  slot_q.wr_hold  <= cfg_data[WAIT_W-1:0];
                    FLD_RECOV:    slot_q.recov    <= cfg_data[WAIT_W-1:0];
                    FLD_RD_DELTA: slot_q.rd_delta <= cfg_data;
                    FLD_WR_DELTA: slot_q.wr_delta <= cfg_data;
                    default:      slot_q          <= slot_q;
                endcase
            end
        end
    end

endmodule

// File: rtl/extbus_page_track.sv
// Module: extbus_page_track
// Remembers the select, page and direction of the last accepted access and
// classifies the incoming request: recovery needed, and new page or not.
// Assumes accept pulses once per transfer, when the request is taken.
module extbus_page_track
    import extbus_pkg::*;
#(
    parameter int IDX_W = CS_W,
    parameter int A_W   = ADDR_W,
    parameter int OFS_W = PAGE_OFS_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             accept,
    input  logic [IDX_W-1:0] req_cs,
    input  logic [A_W-1:0]   req_addr,
    input  logic             req_write,
    output logic             need_rec,
    output logic             new_page,
    output logic [IDX_W-1:0] prev_cs
);

    localparam int PAGE_W = A_W - OFS_W;

    logic              prev_vld_q;
    logic              prev_rd_q;
    logic [IDX_W-1:0]  prev_cs_q;
    logic [PAGE_W-1:0] prev_page_q;
    logic              cs_change;
    logic              page_change;

    // Record the history of the access being accepted
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_vld_q  <= 1'b0;
            prev_rd_q   <= 1'b0;
            prev_cs_q   <= '0;
            prev_page_q <= '0;
        end else if (accept) begin
            prev_vld_q  <= 1'b1;
            prev_rd_q   <= !req_write;
            prev_cs_q   <= req_cs;
            prev_page_q <= req_addr[A_W-1:OFS_W];
        end
    end

    // Classify the pending request against that history
    always_comb begin
        cs_change   = req_cs != prev_cs_q;
        page_change = req_addr[A_W-1:OFS_W] != prev_page_q;
        need_rec    = prev_vld_q && prev_rd_q && (cs_change || req_write);
        new_page    = !prev_vld_q || cs_change || page_change || need_rec;
    end

    assign prev_cs = prev_cs_q;

endmodule

// File: rtl/extbus_seq.sv
// Module: extbus_seq
// Runs one bus transfer through the phases recovery, latency, strobe, hold
// and done, using counts captured at start. Drives all bus pins from
// registered state. Assumes start is only raised while idle is high.
module extbus_seq
    import extbus_pkg::*;
#(
    parameter int N_CS  = NUM_CS,
    parameter int IDX_W = CS_W,
    parameter int A_W   = ADDR_W,
    parameter int D_W   = DATA_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic               st_write,
    input  logic [IDX_W-1:0]   st_cs,
    input  logic [A_W-1:0]     st_addr,
    input  logic [D_W-1:0]     st_wdata,
    input  logic [WAIT_W-1:0]  st_wait,
    input  logic [WAIT_W-1:0]  st_hold,
    input  logic [DELTA_W-1:0] st_lat,
    input  logic               st_rec_en,
    input  logic [WAIT_W-1:0]  st_rec,
    output logic               idle,
    output logic               ack,
    output logic [D_W-1:0]     rdata,
    output logic [N_CS-1:0]    bus_cs_n,
    output logic [A_W-1:0]     bus_addr,
    output logic [D_W-1:0]     bus_dout,
    output logic               bus_dout_en,
    input  logic [D_W-1:0]     bus_din,
    output logic               bus_oe_n,
    output logic               bus_we_n
);

    phase_e             ph_q;
    logic [CNT_W-1:0]   cnt_q;
    logic               s_write;
    logic [IDX_W-1:0]   s_cs;
    logic [A_W-1:0]     s_addr;
    logic [D_W-1:0]     s_wdata;
    logic [WAIT_W-1:0]  s_wait;
    logic [WAIT_W-1:0]  s_hold;
    logic [DELTA_W-1:0] s_lat;
    logic [CNT_W-1:0]   rec_first;
    logic               cs_active;
    logic               last_cnt;

    // First recovery count: a programmed 0 still yields one cycle
    always_comb begin
        rec_first = (st_rec == '0) ? '0 : CNT_W'(st_rec - 1'b1);
        last_cnt  = cnt_q == '0;
    end

    // Phase sequencing, counters and request capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph_q    <= PH_IDLE;
            cnt_q   <= '0;
            s_write <= 1'b0;
            s_cs    <= '0;
            s_addr  <= '0;
            s_wdata <= '0;
            s_wait  <= '0;
            s_hold  <= '0;
            s_lat   <= '0;
            rdata   <= '0;
        end else begin
            case (ph_q)
                PH_IDLE: if (start) begin
                    s_write <= st_write;
                    s_cs    <= st_cs;
                    s_addr  <= st_addr;
                    s_wdata <= st_wdata;
                    s_wait  <= st_wait;
                    s_hold  <= st_hold;
                    s_lat   <= st_lat;
                    if (st_rec_en) begin
                        ph_q  <= PH_REC;
                        cnt_q <= rec_first;
                    end else if (st_lat != '0) begin
                        ph_q  <= PH_LAT;
                        cnt_q <= CNT_W'(st_lat - 1'b1);
                    end else begin
                        ph_q  <= PH_STRB;
                        cnt_q <= CNT_W'(st_wait);
                    end
                end
                PH_REC: if (last_cnt) begin
                    if (s_lat != '0) begin
                        ph_q  <= PH_LAT;
                        cnt_q <= CNT_W'(s_lat - 1'b1);
                    end else begin
                        ph_q  <= PH_STRB;
                        cnt_q <= CNT_W'(s_wait);
                    end
                end else begin
                    cnt_q <= cnt_q - 1'b1;
                end
                PH_LAT: if (last_cnt) begin
                    ph_q  <= PH_STRB;
                    cnt_q <= CNT_W'(s_wait);
                end else begin
                    cnt_q <= cnt_q - 1'b1;
                end
                PH_STRB: begin
                    if (!s_write && last_cnt) rdata <= bus_din;
                    if (last_cnt) begin
                        ph_q  <= s_write ? PH_HOLD : PH_DONE;
                        cnt_q <= CNT_W'(s_hold);
                    end else begin
                        cnt_q <= cnt_q - 1'b1;
                    end
                end
                PH_HOLD: if (last_cnt) begin
                    ph_q <= PH_DONE;
                end else begin
                    cnt_q <= cnt_q - 1'b1;
                end
                PH_DONE: ph_q <= PH_IDLE;
                default: ph_q <= PH_IDLE;
            endcase
        end
    end

    // Pin decode from the registered phase
    always_comb begin
        cs_active   = (ph_q == PH_LAT) || (ph_q == PH_STRB) || (ph_q == PH_HOLD);
        bus_oe_n    = !((ph_q == PH_STRB) && !s_write);
        bus_we_n    = !((ph_q == PH_STRB) && s_write);
        bus_dout_en = s_write && ((ph_q == PH_STRB) || (ph_q == PH_HOLD));
        idle        = ph_q == PH_IDLE;
        ack         = ph_q == PH_DONE;
        bus_addr    = s_addr;
        bus_dout    = s_wdata;
    end

    for (genvar g = 0; g < N_CS; g++) begin : g_csn
        assign bus_cs_n[g] = !(cs_active && (s_cs == IDX_W'(g)));
    end

    // R9
    one_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~bus_cs_n));
    // R2
    strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(!bus_oe_n && !bus_we_n));
    // R4
    no_contention_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_oe_n |-> !bus_dout_en);
    // R4
    drive_at_we_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_we_n |-> bus_dout_en);
    // R3
    hold_after_we_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_we_n) |-> !(&bus_cs_n));
    // R7
    ack_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ack |=> !ack);
    // R7
    ack_after_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ack |-> ((&bus_cs_n) && !$past(&bus_cs_n)));

endmodule

// File: rtl/extbus_ctrl.sv
// Module: extbus_ctrl (top)
// Asynchronous external memory bus controller with per-select timing.
// Accepts a request while idle, classifies it against the previous access,
// snapshots the target select's timing, and hands it to the sequencer.
// Assumes req_cs < N_CS and that request fields are held until req_ack.
module extbus_ctrl
    import extbus_pkg::*;
#(
    parameter int N_CS  = NUM_CS,
    parameter int IDX_W = CS_W,
    parameter int A_W   = ADDR_W,
    parameter int D_W   = DATA_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    input  logic               req_write,
    input  logic [IDX_W-1:0]   req_cs,
    input  logic [A_W-1:0]     req_addr,
    input  logic [D_W-1:0]     req_wdata,
    output logic               req_ack,
    output logic [D_W-1:0]     rsp_rdata,
    input  logic               cfg_we,
    input  logic [IDX_W-1:0]   cfg_cs,
    input  logic [2:0]         cfg_field,
    input  logic [DELTA_W-1:0] cfg_data,
    output logic [N_CS-1:0]    bus_cs_n,
    output logic [A_W-1:0]     bus_addr,
    output logic [D_W-1:0]     bus_dout,
    output logic               bus_dout_en,
    input  logic [D_W-1:0]     bus_din,
    output logic               bus_oe_n,
    output logic               bus_we_n
);

    timing_t [N_CS-1:0] timing_q;
    timing_t            tgt_t;
    timing_t            prv_t;
    logic               seq_idle;
    logic               accept;
    logic               need_rec;
    logic               new_page;
    logic [IDX_W-1:0]   prev_cs;
    logic [WAIT_W-1:0]  sel_wait;
    logic [DELTA_W-1:0] sel_lat;

    extbus_cfg_regs #(.N_CS(N_CS), .IDX_W(IDX_W)) cfg_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_cs    (cfg_cs),
        .cfg_field (cfg_field),
        .cfg_data  (cfg_data),
        .timing_q  (timing_q)
    );

    extbus_page_track #(.IDX_W(IDX_W), .A_W(A_W), .OFS_W(PAGE_OFS_W)) trk_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .accept    (accept),
        .req_cs    (req_cs),
        .req_addr  (req_addr),
        .req_write (req_write),
        .need_rec  (need_rec),
        .new_page  (new_page),
        .prev_cs   (prev_cs)
    );

    // Select the timing of the target and of the previous select
    always_comb begin
        accept   = req_valid && seq_idle;
        tgt_t    = timing_q[req_cs];
        prv_t    = timing_q[prev_cs];
        sel_wait = req_write ? tgt_t.wr_wait : tgt_t.rd_wait;
        sel_lat  = !new_page ? '0 : (req_write ? tgt_t.wr_delta : tgt_t.rd_delta);
    end

    extbus_seq #(.N_CS(N_CS), .IDX_W(IDX_W), .A_W(A_W), .D_W(D_W)) seq_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (accept),
        .st_write    (req_write),
        .st_cs       (req_cs),
        .st_addr     (req_addr),
        .st_wdata    (req_wdata),
        .st_wait     (sel_wait),
        .st_hold     (tgt_t.wr_hold),
        .st_lat      (sel_lat),
        .st_rec_en   (need_rec),
        .st_rec      (prv_t.recov),
        .idle        (seq_idle),
        .ack         (req_ack),
        .rdata       (rsp_rdata),
        .bus_cs_n    (bus_cs_n),
        .bus_addr    (bus_addr),
        .bus_dout    (bus_dout),
        .bus_dout_en (bus_dout_en),
        .bus_din     (bus_din),
        .bus_oe_n    (bus_oe_n),
        .bus_we_n    (bus_we_n)
    );

    // R1
    idle_pins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        seq_idle |-> ((&bus_cs_n) && bus_oe_n && bus_we_n && !bus_dout_en));
    // R9
    addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!(&bus_cs_n) && !(&$past(bus_cs_n))) |-> $stable(bus_addr));

endmodule

// File: tb/extbus_ctrl_tb.sv
module extbus_ctrl_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic [2:0]  req_cs = '0;
    logic [8:0]  req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic        req_ack;
    logic [15:0] rsp_rdata;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_cs = '0, cfg_field = '0;
    logic [7:0]  cfg_data = '0;
    logic [5:0]  bus_cs_n;
    logic [8:0]  bus_addr;
    logic [15:0] bus_dout, bus_din;
    logic        bus_dout_en, bus_oe_n, bus_we_n;

    int total = 0, bad = 0;
    int m_pre, m_cs, m_strb, m_drv;
    bit m_ack_ok, m_addr_bad, m_other_bad, m_data_bad, m_done;
    logic [15:0] m_rd;
    logic [6:0]  oe_seen = '0;

    always #5 clk = ~clk;

    // Bus model: read data reports the count of OE-low cycles so far
    always @(negedge clk) oe_seen <= bus_oe_n ? 7'd0 : oe_seen + 7'd1;
    assign bus_din = {oe_seen, bus_addr};

    extbus_ctrl dut_i (.*);

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic cfg_wr(input logic [2:0] c, input logic [2:0] f, input logic [7:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_cs = c; cfg_field = f; cfg_data = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // One transfer; optional config write in the accept cycle
    task automatic run_acc(input logic w, input logic [2:0] c, input logic [8:0] a,
                           input logic [15:0] d, input bit cf_en,
                           input logic [2:0] cf_f, input logic [7:0] cf_d);
        bit seen = 0, prev_low = 0;
        @(negedge clk);
        req_valid = 1'b1; req_write = w; req_cs = c; req_addr = a; req_wdata = d;
        if (cf_en) begin
            cfg_we = 1'b1; cfg_cs = c; cfg_field = cf_f; cfg_data = cf_d;
        end
        m_pre = 0; m_cs = 0; m_strb = 0; m_drv = 0; m_done = 0;
        m_ack_ok = 0; m_addr_bad = 0; m_other_bad = 0; m_data_bad = 0;
        for (int i = 0; i < 3000; i++) begin
            @(negedge clk);
            cfg_we = 1'b0;
            if (req_ack) begin
                m_ack_ok = prev_low; m_rd = rsp_rdata; req_valid = 1'b0; m_done = 1;
                break;
            end
            if (!seen && (&bus_cs_n)) m_pre++;
            if (!bus_cs_n[c]) begin
                seen = 1; m_cs++;
                if (bus_addr != a) m_addr_bad = 1;
            end
            if ((~bus_cs_n & ~(6'b1 << c)) != 6'b0) m_other_bad = 1;
            if (!bus_oe_n || !bus_we_n) m_strb++;
            if (bus_dout_en) begin
                m_drv++;
                if (bus_dout != d) m_data_bad = 1;
            end
            prev_low = !bus_cs_n[c];
        end
        chk(m_done, "R7 ack seen", m_done, 1);
    endtask

    typedef struct packed {
        logic        wr;
        logic [2:0]  cs;
        logic [8:0]  addr;
        logic [15:0] wd;
        logic [15:0] pre;
        logic [15:0] cslow;
        logic [15:0] strb;
        logic [15:0] drv;
    } vec_t;

    // Ordered sequence: history decides recovery and page latency
    localparam vec_t VECS [12] = '{
        '{1'b0, 3'd0, 9'h010, 16'h0000, 16'd0,  16'd6,   16'd3, 16'd0},
        '{1'b0, 3'd0, 9'h01F, 16'h0000, 16'd0,  16'd3,   16'd3, 16'd0},
        '{1'b1, 3'd0, 9'h01F, 16'h1234, 16'd1,  16'd8,   16'd2, 16'd3},
        '{1'b1, 3'd0, 9'h015, 16'hA5C3, 16'd0,  16'd3,   16'd2, 16'd3},
        '{1'b1, 3'd0, 9'h025, 16'h0F0F, 16'd0,  16'd8,   16'd2, 16'd3},
        '{1'b0, 3'd1, 9'h100, 16'h0000, 16'd0,  16'd1,   16'd1, 16'd0},
        '{1'b0, 3'd5, 9'h1FF, 16'h0000, 16'd2,  16'd260, 16'd5, 16'd0},
        '{1'b1, 3'd5, 9'h1FF, 16'hBEEF, 16'd15, 16'd17,  16'd1, 16'd17},
        '{1'b0, 3'd5, 9'h1F0, 16'h0000, 16'd0,  16'd5,   16'd5, 16'd0},
        '{1'b0, 3'd2, 9'h000, 16'h0000, 16'd15, 16'd1,   16'd1, 16'd0},
        '{1'b0, 3'd2, 9'h001, 16'h0000, 16'd0,  16'd1,   16'd1, 16'd0},
        '{1'b1, 3'd3, 9'h080, 16'h5A5A, 16'd1,  16'd2,   16'd1, 16'd2}
    };

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        chk(0, "watchdog", 0, 1);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        // R1 reset state while held
        chk(bus_cs_n == 6'h3F, "R1 cs_n in reset", bus_cs_n, 6'h3F);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(bus_cs_n == 6'h3F && bus_oe_n && bus_we_n, "R1 strobes idle", {bus_cs_n, bus_oe_n, bus_we_n}, 8'hFF);
        chk(!bus_dout_en && !req_ack, "R1 drive/ack idle", {bus_dout_en, req_ack}, 0);

        // R8 program timing of selects 0, 1 and 5
        cfg_wr(0, 0, 2); cfg_wr(0, 1, 1); cfg_wr(0, 2, 0); cfg_wr(0, 3, 0); cfg_wr(0, 4, 3); cfg_wr(0, 5, 5);
        cfg_wr(1, 0, 0); cfg_wr(1, 1, 3); cfg_wr(1, 2, 2); cfg_wr(1, 3, 2); cfg_wr(1, 4, 0); cfg_wr(1, 5, 1);
        cfg_wr(5, 0, 4); cfg_wr(5, 1, 0); cfg_wr(5, 2, 15); cfg_wr(5, 3, 15); cfg_wr(5, 4, 255); cfg_wr(5, 5, 0);

        foreach (VECS[i]) begin
            run_acc(VECS[i].wr, VECS[i].cs, VECS[i].addr, VECS[i].wd, 0, 0, 0);
            chk(m_pre == int'(VECS[i].pre), "R5 recovery cycles", m_pre, VECS[i].pre);
            chk(m_cs == int'(VECS[i].cslow), "R6 R3 select-low cycles", m_cs, VECS[i].cslow);
            chk(m_strb == int'(VECS[i].strb), "R2 strobe cycles", m_strb, VECS[i].strb);
            chk(m_drv == int'(VECS[i].drv), "R4 drive cycles", m_drv, VECS[i].drv);
            chk(!m_data_bad, "R4 write data", m_data_bad, 0);
            chk(!m_addr_bad && !m_other_bad, "R9 address/select", {m_addr_bad, m_other_bad}, 0);
            chk(m_ack_ok, "R7 ack after select", m_ack_ok, 1);
            if (!VECS[i].wr)
                chk(m_rd == {VECS[i].strb[6:0], VECS[i].addr}, "R7 read sample", m_rd,
                    {VECS[i].strb[6:0], VECS[i].addr});
        end

        // R8 config write in the accept cycle applies only to the next access
        run_acc(0, 3'd4, 9'h040, 0, 1, 3'd0, 8'd6);
        chk(m_strb == 1, "R8 snapshot old value", m_strb, 1);
        run_acc(0, 3'd4, 9'h041, 0, 0, 0, 0);
        chk(m_strb == 7, "R8 new value used", m_strb, 7);
        chk(m_rd == {7'd7, 9'h041}, "R7 read sample late", m_rd, {7'd7, 9'h041});
        // R8 unused field codes ignored
        cfg_wr(4, 3'd6, 8'hFF);
        cfg_wr(4, 3'd7, 8'hFF);
        run_acc(0, 3'd4, 9'h042, 0, 0, 0, 0);
        chk(m_strb == 7 && m_cs == 7 && m_pre == 0, "R8 codes 6/7 ignored", m_cs, 7);
        // R5 write after write: no recovery; R6 new page by address
        run_acc(1, 3'd4, 9'h0F2, 16'h7777, 0, 0, 0);
        chk(m_pre == 1, "R5 read then write", m_pre, 1);
        run_acc(1, 3'd4, 9'h0F3, 16'h8888, 0, 0, 0);
        chk(m_pre == 0 && m_cs == 2, "R5 R6 write after write", m_cs, 2);
        @(negedge clk);
        chk(bus_cs_n == 6'h3F && !req_ack && !bus_dout_en, "R1 idle after traffic", bus_cs_n, 6'h3F);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule